// File: doc/BRIEF.md
# Fractional Clock Divider with Grouped Long Periods

This block divides its source clock by a ratio of the form N + b/a. It emits a one-cycle tick at the end of every output period, a divided clock, and a flag that is high for the whole of any period that is one cycle longer than N. The average output rate is the source rate divided by (N + b/a). The block reaches this by mixing periods of N cycles with periods of N+1 cycles. The order of these periods inside each frame is fixed, so the long periods are spread evenly and no phase accumulator is needed.

A frame holds `a` output periods. The smaller of the two period kinds is called the minor kind and the larger the major kind. The frame is built from z groups, where z is the count of minor periods. Each group holds x major periods and one minor period. The frame then ends with y more major periods. When b is at most a/2, a group is x short periods followed by one long period. When b is above a/2, a group is one short period followed by x long periods. Configuration is written through a strobe into a holding register. The holding register is copied into the working pattern only at a frame boundary, or while the block is idle.

Top module: `frac_clk_div`

## Requirements
- R1: After reset, tick, div_clk and long_per are low. The held configuration is N=2 with a zero fraction, so enabling the block without any write gives periods of exactly 2 cycles.
- R2: One cycle after en is sampled low, tick, div_clk and long_per are all low, and they stay low while en is low. When en is raised again, the next period is period 0 of a fresh frame.
- R3: A value of 0 or 1 on cfg_int is treated as N=2, so no output period is shorter than 2 source cycles.
- R4: Every output period lasts N or N+1 source cycles. tick is high on the last cycle of each period. long_per is high throughout an (N+1) period and low throughout an N period.
- R5: In each frame of `a` consecutive periods, exactly b periods are N+1 cycles long and a-b periods are N cycles long.
- R6: When 0 < b <= a/2, with z=b, x=floor((a-b)/b) and y=(a-b)-z*x, the frame is z groups of (x short periods, then 1 long period), followed by y short periods.
- R7: When b > a/2, with z=a-b, x=floor(b/(a-b)) and y=b-z*x, the frame is z groups of (1 short period, then x long periods), followed by y long periods.
- R8: When b=0, when b>=a, or when a=0, every period is N cycles long and long_per stays low.
- R9: A cfg_wr pulse stores cfg_int, cfg_den and cfg_num. The values take effect at the start of the next frame, or at once while the block is disabled. The frame in progress completes with the old pattern and the old N.
- R10: In a period of P cycles, div_clk is high for the first floor(P/2) cycles and low for the rest. This includes the cycle on which tick is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run control; while low, no ticks are produced |
| cfg_wr | input | 1 | Strobe that stores the three configuration inputs |
| cfg_int | input | NW (8) | Integer divisor N |
| cfg_den | input | DW (6) | Fraction denominator a |
| cfg_num | input | DW (6) | Fraction numerator b |
| div_clk | output | 1 | Divided clock |
| tick | output | 1 | One-cycle pulse on the last cycle of each output period |
| long_per | output | 1 | High during an (N+1)-cycle period |

## Verification
The bench aims at the edges of the pattern arithmetic:
- **b exactly a/2.** Here x=1 and there is no tail, so a design that drops the tail check or miscounts groups would add or skip a period and break the frame total.
- **b just above a/2.** Here the group starts with its single short period, so a design that picks the wrong group template would put the long runs in the wrong order.
- **Degenerate fractions and divisors.** These are b=0, b>=a, a=0, and N of 0 or 1. A design that does not fold them would divide by zero or produce a period of one cycle.
- **Configuration write in mid-frame.** The write must not reshape the rest of that frame, so a design that copies the configuration in at once would change period lengths inside the frame.
- **Re-enable.** Re-enabling must restart at period 0, so a design that keeps its old position would begin in mid-frame.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;
   // Position of the frame sequencer: inside the repeated groups, or in the trailing run
   typedef enum logic {
      PH_GROUP = 1'b0,
      PH_TAIL  = 1'b1
   } frac_phase_e;
endpackage

// File: rtl/frac_pattern_calc.sv
// Derives the group count, group size and tail size from the held configuration.
module frac_pattern_calc #(
   parameter int NW = 8,
   parameter int DW = 6
) (
   input  logic [NW-1:0] int_div,
   input  logic [DW-1:0] den,
   input  logic [DW-1:0] num,
   output logic [NW-1:0] n_eff,
   output logic [DW-1:0] pat_z,
   output logic [DW-1:0] pat_x,
   output logic [DW-1:0] pat_y,
   output logic          pat_long_major,
   output logic          pat_flat
);
   logic [DW-1:0] diff, minor, major, divisor, prod;

   always_comb begin
      // R8: a zero or out-of-range fraction degrades to a plain divide-by-N
      pat_flat       = (num == '0) || (num >= den);
      diff           = den - num;
      pat_long_major = !pat_flat && (num > diff);
      minor          = pat_long_major ? diff : num;
      major          = pat_long_major ? num : diff;
      divisor        = (minor == '0) ? DW'(1) : minor;
      pat_x          = pat_flat ? '0 : (major / divisor);
      prod           = minor * pat_x;
      pat_y          = pat_flat ? '0 : (major - prod);
      pat_z          = pat_flat ? '0 : minor;
      // R3: divisors below two fold to two
      n_eff          = (int_div < NW'(2)) ? NW'(2) : int_div;
   end
endmodule

// File: rtl/frac_frame_seq.sv
// Walks the frame group by group and reports the kind of the current period.
module frac_frame_seq
   import frac_div_pkg::*;
#(
   parameter int DW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reload,
   input  logic          per_end,
   input  logic [DW-1:0] pat_z,
   input  logic [DW-1:0] pat_x,
   input  logic [DW-1:0] pat_y,
   input  logic          pat_long_major,
   input  logic          pat_flat,
   output logic          frame_last,
   output logic          cur_long
);
   logic [DW-1:0] a_z, a_x, a_y;
   logic          a_lm, a_flat;
   logic [DW-1:0] grp, pos, tail;
   frac_phase_e   phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_z    <= '0;
         a_x    <= '0;
         a_y    <= '0;
         a_lm   <= 1'b0;
         a_flat <= 1'b1;
         grp    <= '0;
         pos    <= '0;
         tail   <= '0;
         phase  <= PH_GROUP;
      end else if (reload) begin
         // R9: the working pattern changes only here
         a_z    <= pat_z;
         a_x    <= pat_x;
         a_y    <= pat_y;
         a_lm   <= pat_long_major;
         a_flat <= pat_flat;
         grp    <= '0;
         pos    <= '0;
         tail   <= '0;
         phase  <= PH_GROUP;
      end else if (per_end) begin
         case (phase)
            PH_GROUP: begin
               if (pos == a_x) begin
                  pos <= '0;
                  if (grp == a_z - DW'(1)) begin
                     grp   <= '0;
                     tail  <= '0;
                     phase <= PH_TAIL;
                  end else begin
                     grp <= grp + DW'(1);
                  end
               end else begin
                  pos <= pos + DW'(1);
               end
            end
            default: tail <= tail + DW'(1);
         endcase
      end
   end

   always_comb begin
      if (a_flat)
         frame_last = 1'b1;
      else if (phase == PH_TAIL)
         frame_last = (tail == a_y - DW'(1));
      else
         frame_last = (pos == a_x) && (grp == a_z - DW'(1)) && (a_y == '0);

      // R6 / R7: the group template depends on which kind is in the majority
      if (a_flat)
         cur_long = 1'b0;
      else if (phase == PH_TAIL)
         cur_long = a_lm;
      else if (a_lm)
         cur_long = (pos != '0);
      else
         cur_long = (pos == a_x);
   end
endmodule

// File: rtl/frac_period_ctr.sv
// Counts source cycles within one output period and shapes the divided clock.
module frac_period_ctr #(
   parameter int NW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          reload,
   input  logic [NW-1:0] n_in,
   input  logic          is_long,
   output logic          per_end,
   output logic          div_clk
);
   localparam int CW = NW + 1;

   logic [NW-1:0] a_n;
   logic [CW-1:0] cyc, plen;

   always_comb begin
      plen    = {1'b0, a_n} + CW'(is_long);
      per_end = run && (cyc == plen - CW'(1));
      // R10: high for the first half (rounded down) of the period
      div_clk = run && (cyc < (plen >> 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_n <= NW'(2);
         cyc <= '0;
      end else begin
         if (reload)
            a_n <= n_in;
         if (!run || per_end)
            cyc <= '0;
         else
            cyc <= cyc + CW'(1);
      end
   end
endmodule

// File: rtl/frac_clk_div.sv
// Fractional divider top: configuration holding register, run flag and the two engines.
module frac_clk_div
   import frac_div_pkg::*;
#(
   parameter int NW = 8,
   parameter int DW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          cfg_wr,
   input  logic [NW-1:0] cfg_int,
   input  logic [DW-1:0] cfg_den,
   input  logic [DW-1:0] cfg_num,
   output logic          div_clk,
   output logic          tick,
   output logic          long_per
);
   localparam logic [NW-1:0] RST_INT = NW'(2);
   localparam logic [DW-1:0] RST_DEN = DW'(1);

   if (NW < 2) begin : g_bad_nw
      $error("frac_clk_div: NW must be at least 2");
   end
   if (DW < 2) begin : g_bad_dw
      $error("frac_clk_div: DW must be at least 2");
   end

   logic [NW-1:0] sh_int;
   logic [DW-1:0] sh_den, sh_num;
   logic          run_q;

   logic [NW-1:0] n_eff;
   logic [DW-1:0] pat_z, pat_x, pat_y;
   logic          pat_lm, pat_flat;
   logic          per_end, frame_last, cur_long, reload;

   // R1 / R9: held configuration, reset to N=2 with a zero fraction
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_int <= RST_INT;
         sh_den <= RST_DEN;
         sh_num <= '0;
         run_q  <= 1'b0;
      end else begin
         run_q <= en;
         if (cfg_wr) begin
            sh_int <= cfg_int;
            sh_den <= cfg_den;
            sh_num <= cfg_num;
         end
      end
   end

   // R2 / R9: idle time and frame ends are the only points where a new pattern loads
   assign reload = !run_q || (per_end && frame_last);

   frac_pattern_calc #(.NW(NW), .DW(DW)) i_calc (
      .int_div       (sh_int),
      .den           (sh_den),
      .num           (sh_num),
      .n_eff         (n_eff),
      .pat_z         (pat_z),
      .pat_x         (pat_x),
      .pat_y         (pat_y),
      .pat_long_major(pat_lm),
      .pat_flat      (pat_flat)
   );

   frac_frame_seq #(.DW(DW)) i_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .reload        (reload),
      .per_end       (per_end),
      .pat_z         (pat_z),
      .pat_x         (pat_x),
      .pat_y         (pat_y),
      .pat_long_major(pat_lm),
      .pat_flat      (pat_flat),
      .frame_last    (frame_last),
      .cur_long      (cur_long)
   );

   frac_period_ctr #(.NW(NW)) i_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run_q),
      .reload (reload),
      .n_in   (n_eff),
      .is_long(cur_long),
      .per_end(per_end),
      .div_clk(div_clk)
   );

   assign tick     = per_end;
   assign long_per = run_q && cur_long;
endmodule

// File: rtl/frac_clk_div_chk.sv
// Temporal checks on the divider outputs, attached to every instance of the top.
module frac_clk_div_chk (
   input logic clk,
   input logic rst_n,
   input logic run_q,
   input logic tick,
   input logic div_clk,
   input logic long_per
);
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |-> (!tick && !div_clk && !long_per)); // R2
   AST_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_q) |-> div_clk); // R2
   AST_MIN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick); // R3
   AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !tick) |=> (!run_q || $stable(long_per))); // R4
   AST_LAST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> !div_clk); // R10
   AST_RISE_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (!run_q || div_clk)); // R10
endmodule

bind frac_clk_div frac_clk_div_chk i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .run_q   (run_q),
   .tick    (tick),
   .div_clk (div_clk),
   .long_per(long_per)
);

// File: tb/test_frac_clk_div.sv
`timescale 1ns/1ps
module test_frac_clk_div;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic       cfg_wr = 1'b0;
   logic [7:0] cfg_int = '0;
   logic [5:0] cfg_den = '0;
   logic [5:0] cfg_num = '0;
   logic       div_clk, tick, long_per;
   int         total = 0;
   int         bad = 0;

   always #4 clk = ~clk;

   frac_clk_div i_frac_clk_div (
      .clk(clk), .rst_n(rst_n), .en(en), .cfg_wr(cfg_wr),
      .cfg_int(cfg_int), .cfg_den(cfg_den), .cfg_num(cfg_num),
      .div_clk(div_clk), .tick(tick), .long_per(long_per)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   // Expected kind (1 = N+1 cycles) of period p in a frame, from R6/R7/R8
   function automatic int exp_long(input int a, input int b, input int p);
      int d, mi, ma, x, g, pos;
      bit lm;
      if (b == 0 || b >= a) return 0;
      d  = a - b;
      lm = (b > d);
      mi = lm ? d : b;
      ma = lm ? b : d;
      x  = ma / mi;
      g  = x + 1;
      if (p < mi * g) begin
         pos = p % g;
         return lm ? int'(pos != 0) : int'(pos == x);
      end
      return lm ? 1 : 0;
   endfunction

   task automatic meas(output int len, output int hi, output bit fl);
      bit done;
      len = 0; hi = 0; fl = 1'b0; done = 1'b0;
      while (!done && len < 1000) begin
         @(negedge clk);
         cfg_wr = 1'b0;
         len++;
         if (div_clk) hi++;
         if (tick) begin
            fl = long_per;
            done = 1'b1;
         end
      end
   endtask

   task automatic run_periods(input int n, input int a, input int b,
                              input int start, input int count, input string req);
      int ne, fr, longs, shorts;
      bit flat;
      ne = (n < 2) ? 2 : n;
      flat = (b == 0 || b >= a);
      fr = flat ? 1 : a;
      longs = 0; shorts = 0;
      for (int k = 0; k < count; k++) begin
         int p, e, len, hi;
         bit fl;
         p = (start + k) % fr;
         e = exp_long(a, b, p);
         meas(len, hi, fl);
         chk(len == ne + e, {req, " R4 length"}, len, ne + e);
         chk(int'(fl) == e, {req, " R4 flag"}, int'(fl), e);
         chk(hi == (ne + e) / 2, {req, " R10 high"}, hi, (ne + e) / 2);
         if (start == 0 && k < fr && !flat) begin
            if (len == ne + 1) longs++;
            else shorts++;
         end
      end
      if (start == 0 && !flat && count >= fr) begin
         chk(longs == b, {req, " R5 long count"}, longs, b);
         chk(shorts == a - b, {req, " R5 short count"}, shorts, a - b);
      end
   endtask

   task automatic set_en(input bit v);
      @(negedge clk);
      en = v;
   endtask

   task automatic wr_cfg(input int n, input int a, input int b);
      @(negedge clk);
      cfg_int = 8'(n); cfg_den = 6'(a); cfg_num = 6'(b);
      cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic restart(input int n, input int a, input int b);
      set_en(1'b0);
      repeat (2) @(negedge clk);
      wr_cfg(n, a, b);
      set_en(1'b1);
   endtask

   task automatic t_reset;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk(!tick && !div_clk && !long_per, "R1 reset outputs", {tick, div_clk, long_per}, 0);
      end
      set_en(1'b1);
      run_periods(2, 1, 0, 0, 4, "R1 default divide");
   endtask

   task automatic t_flat;
      restart(6, 5, 0);
      run_periods(6, 5, 0, 0, 3, "R8 zero numerator");
      restart(5, 3, 4);
      run_periods(5, 3, 4, 0, 3, "R8 numerator above denominator");
      restart(3, 0, 0);
      run_periods(3, 0, 0, 0, 3, "R8 zero denominator");
   endtask

   task automatic t_low_b;
      restart(5, 7, 2);
      run_periods(5, 7, 2, 0, 14, "R6 low fraction");
      restart(3, 4, 2);
      run_periods(3, 4, 2, 0, 8, "R6 half fraction");
   endtask

   task automatic t_high_b;
      restart(4, 7, 5);
      run_periods(4, 7, 5, 0, 14, "R7 high fraction");
      restart(2, 5, 4);
      run_periods(2, 5, 4, 0, 10, "R7 single minor");
   endtask

   task automatic t_small_n;
      restart(1, 3, 1);
      run_periods(1, 3, 1, 0, 6, "R3 divisor one");
      restart(0, 2, 1);
      run_periods(0, 2, 1, 0, 4, "R3 divisor zero");
   endtask

   task automatic t_disable;
      restart(4, 5, 2);
      run_periods(4, 5, 2, 0, 2, "R2 before stop");
      en = 1'b0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         chk(!tick && !div_clk && !long_per, "R2 idle outputs", {tick, div_clk, long_per}, 0);
      end
      set_en(1'b1);
      run_periods(4, 5, 2, 0, 5, "R2 restart at period 0");
   endtask

   task automatic t_switch;
      restart(4, 5, 2);
      run_periods(4, 5, 2, 0, 2, "R9 first part");
      cfg_int = 8'd6; cfg_den = 6'd3; cfg_num = 6'd1;
      cfg_wr = 1'b1;
      run_periods(4, 5, 2, 2, 3, "R9 old frame finishes");
      run_periods(6, 3, 1, 0, 3, "R9 new frame");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_flat();
      t_low_b();
      t_high_b();
      t_small_n();
      t_disable();
      t_switch();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule